// File: doc/BRIEF.md
# Shadowed Single-Channel PWM Timer

The block produces one pulse-width-modulated output from a free-running up-counter. A period register sets the length of a cycle, and a compare register sets how long the output stays at its active level within that cycle. Both have a second, shadow copy at a separate address. Software may load new shadow values at any time while the timer runs. The active registers pick them up only when the counter wraps, so the cycle in progress always finishes with the values it started with.

A control register starts and stops the counter, gates the output, inverts the sense of the compare value, and can block an external synchronisation pulse that would otherwise reset the counter. All registers are reached through a plain synchronous port: a write strobe, a read strobe, a byte address and a data word. Read data is registered.

Top module: `ap_pwm_timer`

## Requirements
- R1: After reset every register reads 0, the counter is 0 and `pwm_out` is low.
- R2: Register offsets are control 0x00, active period 0x04, active compare 0x08, shadow period 0x0C and shadow compare 0x10. Read data appears on `bus_rdata` one clock after `bus_re`. Control bits are run=bit 0, output enable=bit 1, invert=bit 2 and sync block=bits 5:4, and all other control bits read 0. Any other address reads 0 and ignores writes.
- R3: While run is set, the counter steps 0,1,...,P and then returns to 0, so one cycle lasts P+1 clocks, where P is the active period.
- R4: While run is clear, the counter keeps its value, and counting resumes from that value when run is set again.
- R5: A high `sync_in` loads the counter with 0 on the next edge unless both sync block bits are 1. With both bits set, the pulse has no effect.
- R6: A write to a shadow register leaves the current cycle unchanged. The new value is copied into the active register on the clock where the counter wraps.
- R7: A shadow value is copied only once per write. A pending flag for each register is cleared by the copy, so a later direct write to the active register is not overwritten at the following wrap.
- R8: `pwm_out` is registered. With invert clear, it is high in the clock after the counter is below the compare value C and low otherwise. Invert reverses this. A value of C above P gives a constant active level.
- R9: While output enable is clear, `pwm_out` is low one clock later, whatever the counter and invert are.
- R10: A write to an active period or compare register takes effect at once, without waiting for a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sync_in | input | 1 | Counter synchronisation pulse |
| pwm_out | output | 1 | PWM output |

## Verification
The checks assume that software never writes the active and shadow copies of a register in the same clock in which a wrap copies the shadow. Where this happens the outcome is defined, but the shadow-copy checks exclude that case. The stimulus writes the shadows early in a long cycle and writes the active registers directly only away from a pending copy. The checks also assume that `sync_in` is a clean synchronous level. The bench drives it on the falling edge for exactly one clock.

// File: rtl/ap_pwm_pkg.sv
package ap_pwm_pkg;

    localparam int ADDR_W = 6;
    localparam int CTRL_W = 16;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_PER  = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_CMP  = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_SPER = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_SCMP = 6'h10;

    localparam int B_RUN     = 0;
    localparam int B_OE      = 1;
    localparam int B_INV     = 2;
    localparam int B_SYNC_LO = 4;

    typedef struct packed {
        logic [1:0] sync_blk;
        logic       inv;
        logic       oe;
        logic       run;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.run      = w[B_RUN];
        c.oe       = w[B_OE];
        c.inv      = w[B_INV];
        c.sync_blk = w[B_SYNC_LO+1:B_SYNC_LO];
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_pack(input ctrl_t c);
        logic [CTRL_W-1:0] w;
        w = '0;
        w[B_RUN] = c.run;
        w[B_OE]  = c.oe;
        w[B_INV] = c.inv;
        w[B_SYNC_LO+1:B_SYNC_LO] = c.sync_blk;
        return w;
    endfunction

endpackage

// File: rtl/ap_pwm_regs.sv
module ap_pwm_regs
    import ap_pwm_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    input  logic [DW-1:0]     wdata,
    input  logic              wrap,
    output logic [DW-1:0]     rdata,
    output ctrl_t             ctrl,
    output logic [DW-1:0]     per_act,
    output logic [DW-1:0]     cmp_act
);

    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] per;
        logic [DW-1:0] cmp;
        logic [DW-1:0] sper;
        logic [DW-1:0] scmp;
        logic          pend_per;
        logic          pend_cmp;
        logic [DW-1:0] rdata;
    } regs_t;

    regs_t s_d, s_q;

    logic wr_per, wr_cmp, wr_sper, wr_scmp, wr_ctrl;

    always_comb begin
        wr_ctrl = we && (addr == OFF_CTRL);
        wr_per  = we && (addr == OFF_PER);
        wr_cmp  = we && (addr == OFF_CMP);
        wr_sper = we && (addr == OFF_SPER);
        wr_scmp = we && (addr == OFF_SCMP);

        s_d = s_q;

        // copy pending shadows on the wrap clock
        if (wrap && s_q.pend_per) begin
            s_d.per      = s_q.sper;
            s_d.pend_per = 1'b0;
        end
        if (wrap && s_q.pend_cmp) begin
            s_d.cmp      = s_q.scmp;
            s_d.pend_cmp = 1'b0;
        end

        // bus writes take precedence over the copy
        if (wr_ctrl) s_d.ctrl = ctrl_unpack(wdata[CTRL_W-1:0]);
        if (wr_per)  s_d.per  = wdata;
        if (wr_cmp)  s_d.cmp  = wdata;
        if (wr_sper) begin
            s_d.sper     = wdata;
            s_d.pend_per = 1'b1;
        end
        if (wr_scmp) begin
            s_d.scmp     = wdata;
            s_d.pend_cmp = 1'b1;
        end

        if (re) begin
            unique case (addr)
                OFF_CTRL: s_d.rdata = DW'(ctrl_pack(s_q.ctrl));
                OFF_PER:  s_d.rdata = s_q.per;
                OFF_CMP:  s_d.rdata = s_q.cmp;
                OFF_SPER: s_d.rdata = s_q.sper;
                OFF_SCMP: s_d.rdata = s_q.scmp;
                default:  s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata   = s_q.rdata;
    assign ctrl    = s_q.ctrl;
    assign per_act = s_q.per;
    assign cmp_act = s_q.cmp;

    AST_SHADOW_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && s_q.pend_per && !wr_per) |=> (per_act == $past(s_q.sper))); // R6
    AST_PER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !wr_per) |=> $stable(per_act)); // R6
    AST_PEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !wr_scmp) |=> !s_q.pend_cmp); // R7

endmodule

// File: rtl/ap_pwm_counter.sv
module ap_pwm_counter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [1:0]    sync_blk,
    input  logic          sync_in,
    input  logic [DW-1:0] per,
    output logic [DW-1:0] cnt,
    output logic          wrap
);

    typedef struct packed {
        logic [DW-1:0] cnt;
    } cnt_t;

    cnt_t s_d, s_q;
    logic sync_hit;

    always_comb begin
        sync_hit = sync_in && (sync_blk != 2'b11);
        wrap     = run && (s_q.cnt >= per);
        s_d      = s_q;
        if (sync_hit)  s_d.cnt = '0;
        else if (wrap) s_d.cnt = '0;
        else if (run)  s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt >= per) |=> (cnt == '0)); // R3
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !sync_in) |=> $stable(cnt)); // R4
    AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in && sync_blk != 2'b11) |=> (cnt == '0)); // R5

endmodule

// File: rtl/ap_pwm_outgen.sv
module ap_pwm_outgen #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          oe,
    input  logic          inv,
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] cmp,
    output logic          pwm
);

    typedef struct packed {
        logic pwm;
    } out_t;

    out_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (oe) s_d.pwm = (cnt < cmp) ^ inv;
        else    s_d.pwm = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pwm = s_q.pwm;

    AST_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |=> !pwm); // R9
    AST_ACTIVE_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && cnt < cmp) |=> (pwm != $past(inv))); // R8

endmodule

// File: rtl/ap_pwm_timer.sv
module ap_pwm_timer
    import ap_pwm_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              sync_in,
    output logic              pwm_out
);

    ctrl_t         ctrl;
    logic [DW-1:0] per_act, cmp_act, cnt;
    logic          wrap;

    ap_pwm_regs #(.DW(DW)) regs_i (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .re(bus_re),
        .wdata(bus_wdata), .wrap(wrap), .rdata(bus_rdata), .ctrl(ctrl),
        .per_act(per_act), .cmp_act(cmp_act)
    );

    ap_pwm_counter #(.DW(DW)) cnt_i (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .sync_blk(ctrl.sync_blk),
        .sync_in(sync_in), .per(per_act), .cnt(cnt), .wrap(wrap)
    );

    ap_pwm_outgen #(.DW(DW)) out_i (
        .clk(clk), .rst_n(rst_n), .oe(ctrl.oe), .inv(ctrl.inv),
        .cnt(cnt), .cmp(cmp_act), .pwm(pwm_out)
    );

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> !pwm_out); // R1

endmodule

// File: tb/ap_pwm_timer_tb_top.sv
module ap_pwm_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sync_in = 1'b0;
    logic        pwm_out;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [5:0] A_CTRL = 6'h00, A_PER = 6'h04, A_CMP = 6'h08,
                           A_SPER = 6'h0C, A_SCMP = 6'h10, A_NONE = 6'h14;

    always #4 clk = ~clk;

    ap_pwm_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sync_in(sync_in), .pwm_out(pwm_out)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string req);
        bus_addr = a; bus_re = 1'b1;
        tick();
        bus_re = 1'b0;
        chk(bus_rdata, exp, req);
    endtask

    function automatic logic lvl(input int c, input int cm, input int inv);
        return ((c < cm) ? 1'b1 : 1'b0) ^ inv[0];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1: reset state
        chk(pwm_out, 0, "R1");
        rd(A_CTRL, 0, "R1"); rd(A_PER, 0, "R1"); rd(A_CMP, 0, "R1");
        rd(A_SPER, 0, "R1"); rd(A_SCMP, 0, "R1");

        // R2: register access
        wr(A_CTRL, 32'h0000_FFFF);
        wr(A_PER, 32'h1234_5678);
        wr(A_CMP, 32'hCAFE_0001);
        wr(A_SPER, 32'h0BAD_F00D);
        wr(A_SCMP, 32'h7777_0000);
        wr(A_NONE, 32'hFFFF_FFFF);
        rd(A_CTRL, 32'h37, "R2");
        rd(A_PER, 32'h1234_5678, "R2");
        rd(A_CMP, 32'hCAFE_0001, "R2");
        rd(A_SPER, 32'h0BAD_F00D, "R2");
        rd(A_SCMP, 32'h7777_0000, "R2");
        rd(A_NONE, 0, "R2");

        // R1: reset in the middle of a run
        do_reset();
        wr(A_PER, 5); wr(A_CMP, 9); wr(A_CTRL, 32'h33);
        tick(); tick();
        chk(pwm_out, 1, "R8");
        do_reset();
        chk(pwm_out, 0, "R1");
        rd(A_PER, 0, "R1");

        // R3 R8: sweep of period, compare and inversion
        for (int p = 0; p <= 5; p++) begin
            for (int c = 0; c <= 7; c++) begin
                for (int iv = 0; iv <= 1; iv++) begin
                    do_reset();
                    wr(A_PER, p);
                    wr(A_CMP, c);
                    wr(A_CTRL, 32'h33 | (iv << 2)); // edge k0
                    for (int i = 0; i < 2 * (p + 1) + 2; i++) begin
                        tick(); // after edge k0+i+1
                        chk(pwm_out, lvl(i % (p + 1), c, iv), "R3_R8");
                    end
                end
            end
        end

        // R6: shadow values wait for the wrap
        do_reset();
        wr(A_PER, 5); wr(A_CMP, 4); wr(A_CTRL, 32'h33); // k0
        wr(A_SPER, 2);                                   // k0+1
        wr(A_SCMP, 1);                                   // k0+2
        tick(); chk(pwm_out, 1, "R6");                   // cnt 2, cmp 4
        tick(); chk(pwm_out, 1, "R6");                   // cnt 3
        tick(); chk(pwm_out, 0, "R6");                   // cnt 4
        tick(); chk(pwm_out, 0, "R6");                   // cnt 5, wrap
        tick(); chk(pwm_out, 1, "R6");                   // cnt 0, cmp 1
        tick(); chk(pwm_out, 0, "R6");                   // cnt 1
        tick(); chk(pwm_out, 0, "R6");                   // cnt 2, wrap
        tick(); chk(pwm_out, 1, "R6");                   // cnt 0
        // R7 R10: direct active write is not overwritten
        wr(A_CMP, 2);                                    // k0+11
        tick(); chk(pwm_out, 0, "R7");                   // cnt 2, wrap
        tick(); chk(pwm_out, 1, "R7");                   // cnt 0
        tick(); chk(pwm_out, 1, "R10");                  // cnt 1 < 2
        rd(A_CMP, 2, "R7");
        rd(A_PER, 2, "R6");

        // R4: counter holds while stopped
        do_reset();
        wr(A_PER, 7); wr(A_CMP, 3); wr(A_CTRL, 32'h33); // k0
        tick();                                          // k0+1
        wr(A_CTRL, 32'h32);                              // k0+2, cnt frozen at 2
        for (int i = 0; i < 8; i++) begin
            tick(); chk(pwm_out, 1, "R4");
        end
        wr(A_CTRL, 32'h33);
        tick(); chk(pwm_out, 1, "R4");
        tick(); chk(pwm_out, 0, "R4");
        tick(); chk(pwm_out, 0, "R4");

        // R5: sync pulse accepted
        do_reset();
        wr(A_PER, 7); wr(A_CMP, 4); wr(A_CTRL, 32'h03); // k0
        repeat (5) tick();                               // cnt 5
        sync_in = 1'b1;
        tick(); sync_in = 1'b0;
        chk(pwm_out, 0, "R5");
        tick(); chk(pwm_out, 1, "R5");
        tick(); chk(pwm_out, 1, "R5");
        // R5: sync pulse blocked
        do_reset();
        wr(A_PER, 7); wr(A_CMP, 4); wr(A_CTRL, 32'h33);
        repeat (5) tick();
        sync_in = 1'b1;
        tick(); sync_in = 1'b0;
        chk(pwm_out, 0, "R5");
        tick(); chk(pwm_out, 0, "R5");
        tick(); chk(pwm_out, 0, "R5");
        tick(); chk(pwm_out, 1, "R5");

        // R9: output enable gate
        do_reset();
        wr(A_PER, 3); wr(A_CMP, 0); wr(A_CTRL, 32'h37);
        tick(); chk(pwm_out, 1, "R9");
        wr(A_CTRL, 32'h35);
        for (int i = 0; i < 6; i++) begin
            tick(); chk(pwm_out, 0, "R9");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule